// File: doc/BRIEF.md
# Condition Evaluator and Branch Unit

This block decides whether a condition holds and steers the program counter. A 4-bit condition selector picks one of sixteen tests over five status flags (zero, sign, overflow, carry and saturation). The result, available combinationally as `condTrue`, feeds both a conditional branch and a set-flag operation that writes 0 or 1 into a destination register.

The block owns the program counter. On every clock edge with a valid operation it loads the next PC. A branch with a short signed displacement is taken when the condition holds and otherwise steps past the short instruction. A register-indirect jump takes its target from a register value supplied by the surrounding core. A jump-and-link uses a long signed displacement and writes the return address to a destination register. A return-address write aimed at register 0 is dropped, which turns the operation into a plain relative jump. Fetch, opcode decode and the register file sit outside the block.

Top module: `branch_cond_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `pcOut` to 0. While no operation is valid, `wrEn` is 0.
- R2: `condTrue` follows `condSel` and `statusFlags`, with flag bits Z=[0], S=[1], OV=[2], CY=[3], SAT=[4]. Codes 0..7 are: OV; CY; Z; CY|Z; S; always true; S^OV; (S^OV)|Z. Codes 8..12, 14 and 15 are the complements of codes 0..4, 6 and 7. Code 13 is SAT.
- R3: A branch (`opKind`=0) whose condition holds loads `pcOut + sext(shortDisp)`, where the 9-bit displacement has bit 0 forced to 0 and is sign-extended to 32 bits.
- R4: A branch whose condition fails loads `pcOut + 2`.
- R5: A set-flag operation (`opKind`=1) drives `wrEn`=1, `wrAddr`=`dstReg` and `wrData`=1 if the condition holds or 0 if it fails, in the same cycle. The PC advances by 4.
- R6: A register jump (`opKind`=2) loads `regValue` into the PC unchanged and writes no register.
- R7: A jump-and-link (`opKind`=3) loads `pcOut + sext(longDisp)`, where the 22-bit displacement has bit 0 forced to 0. In the same cycle it drives `wrEn`=1, `wrAddr`=`dstReg` and `wrData` = old `pcOut` + 4.
- R8: A jump-and-link with `dstReg`=0 keeps `wrEn` at 0 and still jumps.
- R9: With `opValid` low, the PC holds its value and no register write is made.
- R10: `condTrue` is combinational and is valid whether or not `opValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | An operation is presented this cycle |
| opKind | input | 2 | 0 branch, 1 set-flag, 2 register jump, 3 jump-and-link |
| condSel | input | 4 | Condition selector |
| statusFlags | input | 5 | {SAT, CY, OV, S, Z} |
| shortDisp | input | 9 | Branch displacement |
| longDisp | input | 22 | Jump-and-link displacement |
| regValue | input | 32 | Register value for a register jump |
| dstReg | input | 5 | Destination register index |
| condTrue | output | 1 | Selected condition holds |
| pcOut | output | 32 | Current program counter |
| wrEn | output | 1 | Register write strobe |
| wrAddr | output | 5 | Register write index |
| wrData | output | 32 | Register write value |

## Verification
The bench builds the block with its default widths: a 32-bit PC, a 9-bit short displacement and a 22-bit long displacement. At these widths every condition code can be swept against all 32 flag combinations, both standalone and as a branch and a set-flag operation. The displacements used include the odd maximum, the most negative value and small values, so bit-0 clearing and sign extension are exercised at both ends of each field. Return-address writes are tried with destination 0 and a nonzero destination.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  typedef enum logic [1:0] {
    OP_BRANCH   = 2'd0,
    OP_SETFLAG  = 2'd1,
    OP_JUMPREG  = 2'd2,
    OP_JUMPLINK = 2'd3
  } op_kind_e;

  localparam int FLAG_W  = 5;
  localparam int FLG_Z   = 0;
  localparam int FLG_S   = 1;
  localparam int FLG_OV  = 2;
  localparam int FLG_CY  = 3;
  localparam int FLG_SAT = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic useReg;     // PC <= register value
    logic useShort;   // PC <= PC + short offset
    logic useLong;    // PC <= PC + long offset
    logic stepShort;  // PC <= PC + short length
    logic stepLong;   // PC <= PC + long length
    logic linkWr;     // write return address
    logic flagWr;     // write condition bit
  } bcu_ctrl_t;

endpackage

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
  import bcu_pkg::*;
(
  input  logic [3:0]        condSel,
  input  logic [FLAG_W-1:0] flags,
  output logic              condTrue
);

  logic z, s, ov, cy, sat, lessThan, baseTest;

  always_comb begin
    z   = flags[FLG_Z];
    s   = flags[FLG_S];
    ov  = flags[FLG_OV];
    cy  = flags[FLG_CY];
    sat = flags[FLG_SAT];
    lessThan = s ^ ov;
    unique case (condSel[2:0])
      3'd0: baseTest = ov;
      3'd1: baseTest = cy;
      3'd2: baseTest = z;
      3'd3: baseTest = cy | z;
      3'd4: baseTest = s;
      3'd5: baseTest = 1'b0;
      3'd6: baseTest = lessThan;
      3'd7: baseTest = lessThan | z;
    endcase
    // The upper half complements the lower half, except at the
    // always-true slot whose partner tests saturation.
    if (condSel == 4'd5)       condTrue = 1'b1;
    else if (condSel == 4'd13) condTrue = sat;
    else                       condTrue = baseTest ^ condSel[3];
  end

endmodule

// File: rtl/bcu_ctrl.sv
module bcu_ctrl
  import bcu_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic                 opValid,
  input  logic [1:0]           opKind,
  input  logic                 condTrue,
  input  logic [REG_IDX_W-1:0] dstReg,
  output bcu_ctrl_t            ctrl
);

  op_kind_e kind;

  always_comb begin
    kind = op_kind_e'(opKind);
    ctrl = '0;
    if (opValid) begin
      unique case (kind)
        OP_BRANCH: begin
          ctrl.useShort  = condTrue;
          ctrl.stepShort = ~condTrue;
        end
        OP_SETFLAG: begin
          ctrl.flagWr   = 1'b1;
          ctrl.stepLong = 1'b1;
        end
        OP_JUMPREG: begin
          ctrl.useReg = 1'b1;
        end
        OP_JUMPLINK: begin
          ctrl.useLong = 1'b1;
          ctrl.linkWr  = (dstReg != '0);
        end
      endcase
    end
  end

endmodule

// File: rtl/bcu_datapath.sv
module bcu_datapath
  import bcu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SHORT_W   = 9,
  parameter int LONG_W    = 22,
  parameter int REG_IDX_W = 5,
  parameter int SHORT_LEN = 2,
  parameter int LONG_LEN  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  bcu_ctrl_t            ctrl,
  input  logic                 condTrue,
  input  logic [SHORT_W-1:0]   shortDisp,
  input  logic [LONG_W-1:0]    longDisp,
  input  logic [ADDR_W-1:0]    regValue,
  input  logic [REG_IDX_W-1:0] dstReg,
  output logic [ADDR_W-1:0]    pcOut,
  output logic                 wrEn,
  output logic [REG_IDX_W-1:0] wrAddr,
  output logic [ADDR_W-1:0]    wrData
);

  localparam logic [ADDR_W-1:0] STEP_S = ADDR_W'(SHORT_LEN);
  localparam logic [ADDR_W-1:0] STEP_L = ADDR_W'(LONG_LEN);

  logic [ADDR_W-1:0] pcQ, nextPc, shortOff, longOff, returnAddr;

  // Sign-extend with bit 0 cleared to keep targets halfword aligned
  assign shortOff = {{(ADDR_W-SHORT_W){shortDisp[SHORT_W-1]}},
                     shortDisp[SHORT_W-1:1], 1'b0};
  assign longOff  = {{(ADDR_W-LONG_W){longDisp[LONG_W-1]}},
                     longDisp[LONG_W-1:1], 1'b0};
  assign returnAddr = pcQ + STEP_L;

  always_comb begin
    nextPc = pcQ;
    if (ctrl.useReg)         nextPc = regValue;
    else if (ctrl.useShort)  nextPc = pcQ + shortOff;
    else if (ctrl.useLong)   nextPc = pcQ + longOff;
    else if (ctrl.stepShort) nextPc = pcQ + STEP_S;
    else if (ctrl.stepLong)  nextPc = pcQ + STEP_L;
  end

  always_ff @(posedge clk) begin
    if (rst) pcQ <= '0;
    else     pcQ <= nextPc;
  end

  assign pcOut  = pcQ;
  assign wrEn   = ctrl.linkWr | ctrl.flagWr;
  assign wrAddr = dstReg;
  assign wrData = ctrl.flagWr ? ADDR_W'(condTrue) : returnAddr;

endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
  import bcu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SHORT_W   = 9,
  parameter int LONG_W    = 22,
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 opValid,
  input  logic [1:0]           opKind,
  input  logic [3:0]           condSel,
  input  logic [4:0]           statusFlags,
  input  logic [SHORT_W-1:0]   shortDisp,
  input  logic [LONG_W-1:0]    longDisp,
  input  logic [ADDR_W-1:0]    regValue,
  input  logic [REG_IDX_W-1:0] dstReg,
  output logic                 condTrue,
  output logic [ADDR_W-1:0]    pcOut,
  output logic                 wrEn,
  output logic [REG_IDX_W-1:0] wrAddr,
  output logic [ADDR_W-1:0]    wrData
);

  bcu_ctrl_t ctrl;

  bcu_cond_eval u_eval (
    .condSel (condSel),
    .flags   (statusFlags),
    .condTrue(condTrue)
  );

  bcu_ctrl #(.REG_IDX_W(REG_IDX_W)) u_ctrl (
    .opValid (opValid),
    .opKind  (opKind),
    .condTrue(condTrue),
    .dstReg  (dstReg),
    .ctrl    (ctrl)
  );

  bcu_datapath #(
    .ADDR_W   (ADDR_W),
    .SHORT_W  (SHORT_W),
    .LONG_W   (LONG_W),
    .REG_IDX_W(REG_IDX_W),
    .SHORT_LEN(2),
    .LONG_LEN (4)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .condTrue (condTrue),
    .shortDisp(shortDisp),
    .longDisp (longDisp),
    .regValue (regValue),
    .dstReg   (dstReg),
    .pcOut    (pcOut),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData)
  );

endmodule

// File: rtl/bcu_checker.sv
module bcu_checker #(
  parameter int ADDR_W    = 32,
  parameter int REG_IDX_W = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 opValid,
  input logic [1:0]           opKind,
  input logic [3:0]           condSel,
  input logic [4:0]           statusFlags,
  input logic [ADDR_W-1:0]    regValue,
  input logic [REG_IDX_W-1:0] dstReg,
  input logic                 condTrue,
  input logic [ADDR_W-1:0]    pcOut,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    wrData
);

  a_r2_always_code: assert property (@(posedge clk) disable iff (rst)
    condSel == 4'd5 |-> condTrue);

  a_r2_sat_code: assert property (@(posedge clk) disable iff (rst)
    condSel == 4'd13 |-> condTrue == statusFlags[4]);

  a_r2_zero_pair: assert property (@(posedge clk) disable iff (rst)
    condSel == 4'd2 |-> condTrue == statusFlags[0]);

  a_r4_untaken_step: assert property (@(posedge clk) disable iff (rst)
    opValid && opKind == 2'd0 && !condTrue |=> pcOut == $past(pcOut) + ADDR_W'(2));

  a_r5_flag_write: assert property (@(posedge clk) disable iff (rst)
    opValid && opKind == 2'd1 |-> wrEn && wrData == ADDR_W'(condTrue));

  a_r6_reg_jump: assert property (@(posedge clk) disable iff (rst)
    opValid && opKind == 2'd2 |=> pcOut == $past(regValue));

  a_r8_link_r0_dropped: assert property (@(posedge clk) disable iff (rst)
    opValid && opKind == 2'd3 && dstReg == '0 |-> !wrEn);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> $stable(pcOut));

  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    !opValid |-> !wrEn);

endmodule

bind branch_cond_unit bcu_checker #(.ADDR_W(ADDR_W), .REG_IDX_W(REG_IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .opValid    (opValid),
  .opKind     (opKind),
  .condSel    (condSel),
  .statusFlags(statusFlags),
  .regValue   (regValue),
  .dstReg     (dstReg),
  .condTrue   (condTrue),
  .pcOut      (pcOut),
  .wrEn       (wrEn),
  .wrData     (wrData)
);

// File: tb/branch_cond_unit_tb.sv
`timescale 1ns/1ps
module branch_cond_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        opValid;
  logic [1:0]  opKind;
  logic [3:0]  condSel;
  logic [4:0]  statusFlags;
  logic [8:0]  shortDisp;
  logic [21:0] longDisp;
  logic [31:0] regValue;
  logic [4:0]  dstReg;
  logic        condTrue;
  logic [31:0] pcOut;
  logic        wrEn;
  logic [4:0]  wrAddr;
  logic [31:0] wrData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  logic [31:0] mpc;

  always #2.5 clk = ~clk;

  branch_cond_unit u_dut (
    .clk(clk), .rst(rst), .opValid(opValid), .opKind(opKind),
    .condSel(condSel), .statusFlags(statusFlags), .shortDisp(shortDisp),
    .longDisp(longDisp), .regValue(regValue), .dstReg(dstReg),
    .condTrue(condTrue), .pcOut(pcOut), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData)
  );

  // Flag order: Z=[0] S=[1] OV=[2] CY=[3] SAT=[4]
  function automatic logic refCond(input logic [3:0] c, input logic [4:0] f);
    logic z, s, ov, cy, sat;
    z = f[0]; s = f[1]; ov = f[2]; cy = f[3]; sat = f[4];
    case (c)
      4'd0:  return ov;
      4'd1:  return cy;
      4'd2:  return z;
      4'd3:  return cy || z;
      4'd4:  return s;
      4'd5:  return 1'b1;
      4'd6:  return s != ov;
      4'd7:  return (s != ov) || z;
      4'd8:  return !ov;
      4'd9:  return !cy;
      4'd10: return !z;
      4'd11: return !(cy || z);
      4'd12: return !s;
      4'd13: return sat;
      4'd14: return s == ov;
      default: return !((s != ov) || z);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a negedge; returns just after the next negedge.
  task automatic doOp(input logic [1:0] k, input logic [3:0] c, input logic [4:0] f,
                      input logic [8:0] sd, input logic [21:0] ld,
                      input logic [31:0] rv, input logic [4:0] d);
    logic e;
    logic [31:0] nxt;
    opValid = 1'b1; opKind = k; condSel = c; statusFlags = f;
    shortDisp = sd; longDisp = ld; regValue = rv; dstReg = d;
    #1;
    e = refCond(c, f);
    case (k)
      2'd0: begin
        nxt = e ? mpc + ({{23{sd[8]}}, sd} & 32'hFFFF_FFFE) : mpc + 32'd2;
        chk(wrEn == 1'b0, "R3 branch writes nothing", {31'd0, wrEn}, 32'd0);
      end
      2'd1: begin
        nxt = mpc + 32'd4;
        chk(wrEn && wrAddr == d && wrData == {31'd0, e}, "R5 set-flag write",
            wrData, {31'd0, e});
      end
      2'd2: begin
        nxt = rv;
        chk(wrEn == 1'b0, "R6 register jump writes nothing", {31'd0, wrEn}, 32'd0);
      end
      default: begin
        nxt = mpc + ({{10{ld[21]}}, ld} & 32'hFFFF_FFFE);
        if (d == 5'd0)
          chk(wrEn == 1'b0, "R8 link to r0 suppressed", {31'd0, wrEn}, 32'd0);
        else
          chk(wrEn && wrAddr == d && wrData == mpc + 32'd4, "R7 link value",
              wrData, mpc + 32'd4);
      end
    endcase
    @(negedge clk);
    opValid = 1'b0;
    if (k == 2'd0)
      chk(pcOut == nxt, e ? "R3 branch taken" : "R4 branch untaken", pcOut, nxt);
    else if (k == 2'd1)
      chk(pcOut == nxt, "R5 set-flag pc step", pcOut, nxt);
    else if (k == 2'd2)
      chk(pcOut == nxt, "R6 register jump target", pcOut, nxt);
    else
      chk(pcOut == nxt, "R7 jump-and-link target", pcOut, nxt);
    mpc = nxt;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    rst = 1'b1; opValid = 1'b1; opKind = 2'd3; condSel = 4'd0; statusFlags = 5'd0;
    shortDisp = '0; longDisp = 22'h100; regValue = '0; dstReg = 5'd0;
    repeat (3) @(negedge clk);
    opValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(pcOut == 32'd0, "R1 reset pc", pcOut, 32'd0);
    #1;
    chk(wrEn == 1'b0, "R1 idle no write", {31'd0, wrEn}, 32'd0);
    mpc = 32'd0;
    @(negedge clk);

    // R10/R2: full condition sweep with no operation; R9 hold
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f++) begin
        condSel = 4'(c); statusFlags = 5'(f);
        #1;
        chk(condTrue == refCond(4'(c), 5'(f)), "R2 R10 condition table",
            {31'd0, condTrue}, {31'd0, refCond(4'(c), 5'(f))});
        if (f == 31) begin
          @(negedge clk);
          chk(pcOut == mpc && !wrEn, "R9 idle holds pc", pcOut, mpc);
        end
      end
    end

    // R3/R4: branches across every condition and flag pattern
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f++) begin
        logic [8:0] sd;
        case ((c + f) % 4)
          0: sd = 9'h0FF;
          1: sd = 9'h100;
          2: sd = 9'h001;
          default: sd = 9'h1FE;
        endcase
        doOp(2'd0, 4'(c), 5'(f), sd, 22'd0, 32'd0, 5'd7);
      end
    end

    // R5: set-flag across every condition and flag pattern
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 32; f++)
        doOp(2'd1, 4'(c), 5'(f), 9'd0, 22'd0, 32'd0, 5'(c + f));

    // R6: register jumps, including odd and zero targets
    doOp(2'd2, 4'd0, 5'd0, 9'd0, 22'd0, 32'h1234_5679, 5'd3);
    doOp(2'd2, 4'd8, 5'd31, 9'd0, 22'd0, 32'hFFFF_FFFE, 5'd0);
    doOp(2'd2, 4'd5, 5'd4, 9'd0, 22'd0, 32'h0000_0000, 5'd9);

    // R7/R8: jump-and-link at displacement extremes, r0 and non-r0
    doOp(2'd3, 4'd0, 5'd0, 9'd0, 22'h1F_FFFF, 32'd0, 5'd31);
    doOp(2'd3, 4'd0, 5'd0, 9'd0, 22'h20_0000, 32'd0, 5'd0);
    doOp(2'd3, 4'd9, 5'd8, 9'd0, 22'h00_0003, 32'd0, 5'd1);
    doOp(2'd3, 4'd2, 5'd1, 9'd0, 22'h3F_FFFE, 32'd0, 5'd0);
    doOp(2'd3, 4'd2, 5'd1, 9'd0, 22'h00_0400, 32'd0, 5'd12);

    // R9: idle cycles leave pc untouched and make no write
    repeat (3) @(negedge clk);
    chk(pcOut == mpc && !wrEn, "R9 idle after ops", pcOut, mpc);

    // R1: reset while an operation is presented
    opValid = 1'b1; opKind = 2'd2; regValue = 32'hABCD_0000; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; opValid = 1'b0;
    chk(pcOut == 32'd0, "R1 reset overrides operation", pcOut, 32'd0);

    finishRun();
  end

endmodule